// File: doc/BRIEF.md
# Command Completion Event Counter

Each channel of a command-list DMA engine needs to tell software how many commands have finished since software last looked. This block keeps that tally for one channel. A hardware count advances by one on every command event pulse. A second count holds the number of events that software has already handled. Both counts wrap at the same modulus, so software learns how many events are pending by subtracting the handled count from the hardware count, modulo the count range.

Software sees one status word and can write it. An acknowledge is a write that loads the handled count and clears an interrupt-active flag. The flag is set by every event. The block drives a level-sensitive, active-high interrupt. That interrupt stays high while the two counts differ or while the flag is set. The hardware count cannot be written. An event never gets lost, even when it arrives in the same cycle as an acknowledge write. Software can therefore read again after it acknowledges and find any event that slipped in between.

Top module: `evt_tally`

## Requirements
- R1: After reset the status word reads all zeros and `irq_o` is low.
- R2: Each cycle with `evt_i` high adds one to the done count in status bits [5:0]. The count wraps from 63 to 0, and it is visible on `rd_data_o` from the following cycle.
- R3: A write (`wr_en_i` high) loads status bits [21:16], the processed count, from `wr_data_i[21:16]`. The write leaves the done count at bits [5:0] exactly as events alone would make it, whatever `wr_data_i[5:0]` holds.
- R4: Bit 8 is the interrupt-active flag. Any event sets it. A write with `wr_data_i[8]` = 0 clears it. A write with `wr_data_i[8]` = 1 leaves it unchanged.
- R5: `irq_o` is high exactly when the done count differs from the processed count, or when the active flag is set. Pending events are therefore counted as done minus processed, modulo 64.
- R6: When an event and a write fall in the same cycle, the done count still advances and the active flag ends up set, while the processed count takes the written value.
- R7: Status bits other than [5:0], 8 and [21:16] always read zero, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | One-cycle pulse per command event |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Status word write data |
| rd_data_o | output | 32 | Current status word |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The critical collision is an event pulse in the same cycle as an acknowledge write that clears the flag and loads the processed count. The bench provokes it several times. It does so with an acknowledge value equal to the old done count, so the only thing keeping the interrupt up afterwards is the late event. It also does so with the done count at 63, so the increment wraps in the collision cycle. A reference model in the bench applies the event after the write. Each collision is judged on the next cycle's status word and interrupt: the done count must be one higher, the flag must be set and `irq_o` must be high.

// File: rtl/evt_tally.sv
module evt_tally #(
  parameter int CNT_W    = 6,
  parameter int WORD_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int ACT_POS  = 8,
  parameter int PROC_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);

  localparam int DONE_MSB = DONE_LSB + CNT_W - 1;
  localparam int PROC_MSB = PROC_LSB + CNT_W - 1;

  logic [CNT_W-1:0] done_q;
  logic [CNT_W-1:0] proc_q;
  logic             act_q;
  logic             ack_clr;

  assign ack_clr = wr_en_i & ~wr_data_i[ACT_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      proc_q <= '0;
      act_q  <= 1'b0;
    end else begin
      if (evt_i)   done_q <= done_q + 1'b1;
      if (wr_en_i) proc_q <= wr_data_i[PROC_MSB:PROC_LSB];
      act_q <= evt_i | (act_q & ~ack_clr);
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[DONE_MSB:DONE_LSB] = done_q;
    rd_data_o[ACT_POS]           = act_q;
    rd_data_o[PROC_MSB:PROC_LSB] = proc_q;
  end

  assign irq_o = (done_q != proc_q) | act_q;

endmodule

// File: rtl/evt_tally_chk.sv
module evt_tally_chk #(
  parameter int CNT_W    = 6,
  parameter int WORD_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int ACT_POS  = 8,
  parameter int PROC_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_i,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              irq_o
);

  localparam int DONE_MSB = DONE_LSB + CNT_W - 1;
  localparam int PROC_MSB = PROC_LSB + CNT_W - 1;

  logic [CNT_W-1:0] done_v;
  logic [CNT_W-1:0] proc_v;
  logic             act_v;
  assign done_v = rd_data_o[DONE_MSB:DONE_LSB];
  assign proc_v = rd_data_o[PROC_MSB:PROC_LSB];
  assign act_v  = rd_data_o[ACT_POS];

  p_done_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> done_v == CNT_W'($past(done_v) + 1'b1));

  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> $stable(done_v));

  p_proc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> proc_v == $past(wr_data_i[PROC_MSB:PROC_LSB]));

  p_act_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> act_v && irq_o);

  p_act_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[ACT_POS] && !evt_i) |=> !act_v);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_en_i) |=> irq_o);

endmodule

bind evt_tally evt_tally_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .DONE_LSB(DONE_LSB),
  .ACT_POS(ACT_POS), .PROC_LSB(PROC_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
);

// File: tb/evt_tally_tb_top.sv
module evt_tally_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  always #5 clk = ~clk;

  evt_tally dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] word;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0;
  int mismatched = 0;

  logic [5:0] m_done = '0;
  logic [5:0] m_proc = '0;
  logic       m_act  = 1'b0;

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[5:0]   = m_done;
    w[8]     = m_act;
    w[21:16] = m_proc;
    return w;
  endfunction

  task automatic compare(input logic [31:0] w, input logic q, input exp_t e);
    compared++;
    if (w !== e.word || q !== e.irq) begin
      mismatched++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               e.tag, w, q, e.word, e.irq);
    end
  endtask

  task automatic step(input logic ev, input logic wr, input logic [31:0] d,
                      input string tag);
    exp_t e;
    @(negedge clk);
    evt_i = ev; wr_en_i = wr; wr_data_i = d;
    if (wr) begin
      m_proc = d[21:16];
      if (!d[8]) m_act = 1'b0;
    end
    if (ev) begin
      m_done = m_done + 6'd1;
      m_act  = 1'b1;
    end
    e.word = model_word();
    e.irq  = (m_done != m_proc) || m_act;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] ack(input logic [5:0] p, input logic keep);
    logic [31:0] w = '0;
    w[21:16] = p;
    w[8]     = keep;
    return w;
  endfunction

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(rd_data_o, irq_o, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #500000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    exp_t r;
    #22;
    r.word = '0; r.irq = 1'b0; r.tag = "R1 reset state";
    compare(rd_data_o, irq_o, r);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, "R2 event count");
    step(1'b0, 1'b0, '0, "R5 irq while pending");
    step(1'b0, 1'b1, ack(6'd3, 1'b0) | 32'h3F, "R3 ack, done field write ignored");
    step(1'b0, 1'b0, '0, "R5 irq low when caught up");

    step(1'b1, 1'b0, '0, "R4 event sets active");
    step(1'b0, 1'b1, ack(6'd4, 1'b1), "R4 write of one keeps active");
    step(1'b0, 1'b1, ack(6'd4, 1'b0), "R4 write of zero clears active");

    step(1'b1, 1'b0, '0, "R6 event before collision");
    step(1'b1, 1'b1, ack(6'd5, 1'b0), "R6 event with ack same cycle");
    step(1'b0, 1'b0, '0, "R6 late event still pending");
    step(1'b0, 1'b1, ack(6'd6, 1'b0), "R6 ack of late event");

    step(1'b0, 1'b1, ack(6'd2, 1'b0), "R5 counts differ, flag clear");

    for (int i = 0; i < 57; i++) step(1'b1, 1'b0, '0, "R2 advance to 63");
    step(1'b0, 1'b1, ack(6'd63, 1'b0), "R5 ack at 63");
    step(1'b1, 1'b1, ack(6'd63, 1'b0), "R2 R6 wrap during collision");
    step(1'b0, 1'b1, ack(6'd0, 1'b0), "R5 ack after wrap");

    step(1'b0, 1'b1, ack(6'd0, 1'b0), "R5 pending mod 64 setup");
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0, '0, "R2 full lap");
    step(1'b0, 1'b1, ack(6'd0, 1'b0), "R5 full lap acked");

    step(1'b0, 1'b1, 32'hFFC0_FEC0 | ack(6'd0, 1'b1), "R7 unused bits read zero");
    step(1'b1, 1'b1, 32'hFFFF_FFFF, "R7 R3 all ones write with event");
    step(1'b0, 1'b1, ack(6'd1, 1'b0), "R4 final ack");
    step(1'b0, 1'b0, '0, "R1 idle");

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule